// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Collector

This block collects 64 interrupt request lines and reduces them to one CPU interrupt output with a ready-made vector address. Each source has a control byte with a 2-bit priority level, an enable, and a software request that behaves like an asserted line. Among enabled pending sources the block picks the highest level, and the lowest source number on a tie. It raises `cpu_irq` only when that level is strictly above every level already in service. The winning source number is reported in a status register. The vector register returns a programmable table base plus four times that number.

Service entry can happen in one of two ways, chosen by a control bit: a write to the vector register, or a read of it. Entry marks the winner's level as in service. Software ends a level by writing a one-hot mask to the level-acknowledge register, which lets requests at or below that level interrupt again. A control bit can turn nesting off, so nothing is presented while any level is in service. Access is over a 32-bit register bus with registered read data. Address bits 3:2 of every register select one of four write actions: plain write, set bits, clear bits or toggle bits.

Top module: `irq_collector`

## Requirements
- R1: After reset `cpu_irq` is 0, and the control register (0x020), the table base (0x160) and every source control register read 0.
- R2: Source n's control byte sits in the register at 0x060 + 0x10*(n/4), at bits 8*(n mod 4) upward. Byte bits 1:0 are the level, bit 2 is the enable and bit 3 is the software request. Byte bits 7:4 read 0.
- R3: Address bits 3:2 of a write select the action: 0 stores the data, 1 ORs it in, 2 clears the bits that are 1 in the data, 3 inverts the bits that are 1 in the data. Control keeps only bits 16, 18 and 19. The table base keeps bits 31:2.
- R4: Registers 0x040 and 0x050 return request lines 31:0 and 63:32 as they are, without enables and without software requests. Writes to these registers are ignored.
- R5: `cpu_irq` is 1 exactly one cycle after the block's state allows a presentable request while control bit 16 is set. It stays 0 while bit 16 is clear.
- R6: The presented source is the enabled pending source with the highest level. Among sources at that level, the lowest number wins.
- R7: The vector register (0x000) reads table base + 4*id and the status register (0x030) reads id in bits 5:0. Here id is the presentable source if there is one, otherwise the source that entered service most recently.
- R8: With control bit 18 at 0, a write to 0x000 puts the presentable source in service and a read of 0x000 does not.
- R9: With control bit 18 at 1, a read of 0x000 puts the presentable source in service. That read returns its vector.
- R10: While a level is in service, only sources at a strictly higher level are presented. Writing a mask with bit L set to 0x010 ends service on level L.
- R11: With control bit 19 set, nothing is presented while any level is in service.
- R12: A source's software request bit makes it pending even when its line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 64 | Raw interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address; bits 3:2 select the write action |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
Every result here sits behind one register. Read data appears the cycle after the read strobe. `cpu_irq` reflects the state one edge earlier: a configuration write, a line change, a service entry or an acknowledge committed at edge k shows up on `cpu_irq` at edge k+1. The bench drives and samples on falling edges. Right after a write that completes at edge k, it checks that `cpu_irq` still shows the old value. After one more falling edge it checks the new value. Level checks after a line change wait two falling edges.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  localparam int LVL_W = 2;

  localparam logic [11:0] OFS_VECTOR = 12'h000;
  localparam logic [11:0] OFS_LVLACK = 12'h010;
  localparam logic [11:0] OFS_CTRL   = 12'h020;
  localparam logic [11:0] OFS_STAT   = 12'h030;
  localparam logic [11:0] OFS_RAW    = 12'h040;
  localparam logic [11:0] OFS_SRC    = 12'h060;

  localparam int CB_IRQ_EN     = 16;
  localparam int CB_READ_ENTRY = 18;
  localparam int CB_NO_NEST    = 19;

  function automatic logic [31:0] alias_apply(input alias_op_e op,
                                              input logic [31:0] cur,
                                              input logic [31:0] wd,
                                              input logic [31:0] keep);
    logic [31:0] r;
    case (op)
      OP_WRITE: r = wd;
      OP_SET:   r = cur | wd;
      OP_CLR:   r = cur & ~wd;
      default:  r = cur ^ wd;
    endcase
    return r & keep;
  endfunction

endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [$clog2(NUM_SRC/4)-1:0]      wr_idx,
  input  alias_op_e                         wr_op,
  input  logic [31:0]                       wr_data,
  input  logic [$clog2(NUM_SRC/4)-1:0]      rd_idx,
  output logic [31:0]                       rd_data,
  output logic [NUM_SRC-1:0]                src_en,
  output logic [NUM_SRC-1:0]                src_soft,
  output logic [NUM_SRC-1:0][LVL_W-1:0]     src_prio
);
  localparam int NREG  = NUM_SRC / 4;
  localparam int IDX_W = $clog2(NREG);
  localparam logic [31:0] BYTE_KEEP = 32'h0F0F_0F0F;

  logic [NREG-1:0][31:0] ctl_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q[r] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(r)) begin
        ctl_q[r] <= alias_apply(wr_op, ctl_q[r], wr_data, BYTE_KEEP);
      end
    end
  end

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assign src_prio[n] = ctl_q[n/4][8*(n%4) +: LVL_W];
    assign src_en[n]   = ctl_q[n/4][8*(n%4) + 2];
    assign src_soft[n] = ctl_q[n/4][8*(n%4) + 3];
  end

  assign rd_data = ctl_q[rd_idx];

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]            req,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] prio,
  output logic                          win_valid,
  output logic [$clog2(NUM_SRC)-1:0]    win_id,
  output logic [LVL_W-1:0]              win_lvl
);
  localparam int ID_W = $clog2(NUM_SRC);

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_lvl   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i] && (!win_valid || prio[i] >= win_lvl)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_lvl   = prio[i];
      end
    end
  end

endmodule

// File: rtl/irqc_level_tracker.sv
module irqc_level_tracker
  import irqc_pkg::*;
#(
  parameter int NUM_LVL = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enter,
  input  logic [LVL_W-1:0]   enter_lvl,
  input  logic               ack,
  input  logic [NUM_LVL-1:0] ack_mask,
  output logic [NUM_LVL-1:0] inserv,
  output logic               busy,
  output logic [LVL_W-1:0]   top_lvl
);
  logic [NUM_LVL-1:0] inserv_q, inserv_d;

  always_comb begin
    inserv_d = inserv_q;
    if (ack)   inserv_d = inserv_d & ~ack_mask;
    if (enter) inserv_d[enter_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) inserv_q <= '0;
    else     inserv_q <= inserv_d;
  end

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (inserv_q[l]) top_lvl = LVL_W'(l);
    end
  end

  assign busy   = |inserv_q;
  assign inserv = inserv_q;

endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               cpu_irq
);
  localparam int NUM_LVL   = 1 << LVL_W;
  localparam int ID_W      = $clog2(NUM_SRC);
  localparam int NREG      = NUM_SRC / 4;
  localparam int IDX_W     = $clog2(NREG);
  localparam int RAW_WORDS = NUM_SRC / 32;
  localparam logic [11:0] OFS_TBASE = OFS_SRC + 12'(NREG * 16);
  localparam logic [31:0] CTRL_KEEP = (32'd1 << CB_IRQ_EN) | (32'd1 << CB_READ_ENTRY)
                                    | (32'd1 << CB_NO_NEST);
  localparam logic [31:0] TBASE_KEEP = 32'hFFFF_FFFC;

  // Address decode
  logic [11:0] reg_ofs, src_off;
  alias_op_e   op;
  logic        src_hit;
  logic [IDX_W-1:0] src_idx;
  logic        unused_bits;

  assign reg_ofs = {bus_addr[11:4], 4'h0};
  assign op      = alias_op_e'(bus_addr[3:2]);
  assign src_off = reg_ofs - OFS_SRC;
  assign src_hit = (reg_ofs >= OFS_SRC) && (reg_ofs < OFS_TBASE);
  assign src_idx = src_off[4 +: IDX_W];
  assign unused_bits = &{1'b0, bus_addr[1:0], src_off[3:0], src_off[11:4+IDX_W],
                         bus_wdata[31:NUM_LVL]};

  // Control and table base
  logic [31:0] ctrl_q, tbase_q;
  logic irq_en, read_mode, no_nest;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      tbase_q <= '0;
    end else if (bus_wr) begin
      if (reg_ofs == OFS_CTRL)  ctrl_q  <= alias_apply(op, ctrl_q, bus_wdata, CTRL_KEEP);
      if (reg_ofs == OFS_TBASE) tbase_q <= alias_apply(op, tbase_q, bus_wdata, TBASE_KEEP);
    end
  end

  assign irq_en    = ctrl_q[CB_IRQ_EN];
  assign read_mode = ctrl_q[CB_READ_ENTRY];
  assign no_nest   = ctrl_q[CB_NO_NEST];

  // Per-source control
  logic [NUM_SRC-1:0]            src_en, src_soft;
  logic [NUM_SRC-1:0][LVL_W-1:0] src_prio;
  logic [31:0]                   src_rd;

  irqc_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr && src_hit),
    .wr_idx   (src_idx),
    .wr_op    (op),
    .wr_data  (bus_wdata),
    .rd_idx   (src_idx),
    .rd_data  (src_rd),
    .src_en   (src_en),
    .src_soft (src_soft),
    .src_prio (src_prio)
  );

  // Selection
  logic [NUM_SRC-1:0] req;
  logic               win_valid;
  logic [ID_W-1:0]    win_id;
  logic [LVL_W-1:0]   win_lvl;

  assign req = (irq_lines | src_soft) & src_en;

  irqc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .req       (req),
    .prio      (src_prio),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_lvl   (win_lvl)
  );

  // Service tracking
  logic               enter, ack, busy, presentable;
  logic [NUM_LVL-1:0] inserv, ack_mask;
  logic [LVL_W-1:0]   top_lvl, enter_lvl;

  assign presentable = win_valid &&
                       (no_nest ? !busy : (!busy || win_lvl > top_lvl));
  assign enter     = presentable && (reg_ofs == OFS_VECTOR) &&
                     ((bus_wr && !read_mode) || (bus_rd && read_mode));
  assign enter_lvl = win_lvl;
  assign ack       = bus_wr && (reg_ofs == OFS_LVLACK);
  assign ack_mask  = bus_wdata[NUM_LVL-1:0];

  irqc_level_tracker #(.NUM_LVL(NUM_LVL)) u_lvl (
    .clk       (clk),
    .rst       (rst),
    .enter     (enter),
    .enter_lvl (enter_lvl),
    .ack       (ack),
    .ack_mask  (ack_mask),
    .inserv    (inserv),
    .busy      (busy),
    .top_lvl   (top_lvl)
  );

  logic [ID_W-1:0] active_id, shown_id;
  logic [31:0]     vec_val, rd_mux;

  always_ff @(posedge clk) begin
    if (rst)        active_id <= '0;
    else if (enter) active_id <= win_id;
  end

  assign shown_id = presentable ? win_id : active_id;
  assign vec_val  = {tbase_q[31:2], 2'b00} + (32'(shown_id) << 2);

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < RAW_WORDS; w++) begin
      if (reg_ofs == OFS_RAW + 12'(w * 16)) rd_mux = irq_lines[w*32 +: 32];
    end
    if (reg_ofs == OFS_VECTOR)     rd_mux = vec_val;
    else if (reg_ofs == OFS_CTRL)  rd_mux = ctrl_q;
    else if (reg_ofs == OFS_STAT)  rd_mux = 32'(shown_id);
    else if (reg_ofs == OFS_TBASE) rd_mux = tbase_q;
    else if (src_hit)              rd_mux = src_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      cpu_irq <= irq_en && presentable;
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_LVL = 4,
  parameter int LVL_W   = 2,
  parameter int ID_W    = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_irq,
  input logic               irq_en,
  input logic               no_nest,
  input logic [NUM_LVL-1:0] inserv,
  input logic               enter,
  input logic [LVL_W-1:0]   enter_lvl,
  input logic               ack,
  input logic [NUM_LVL-1:0] ack_mask,
  input logic [ID_W-1:0]    active_id
);
  p_irq_gated_r5: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> $past(irq_en));

  p_quiet_no_nest_r11: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq && $past(no_nest)) |-> ($past(inserv) == '0));

  p_entry_marks_level_r10: assert property (@(posedge clk) disable iff (rst)
    $past(enter) |-> ((inserv & (NUM_LVL'(1) << $past(enter_lvl))) != '0));

  p_level_set_needs_entry_r8: assert property (@(posedge clk) disable iff (rst)
    ((inserv & ~$past(inserv)) != '0) |-> $past(enter));

  p_id_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(enter) |-> $stable(active_id));

  p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
    $past(ack) |-> ((inserv & $past(ack_mask)) == '0));

endmodule

bind irq_collector irqc_checker #(
  .NUM_LVL (NUM_LVL),
  .LVL_W   (irqc_pkg::LVL_W),
  .ID_W    (ID_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_irq   (cpu_irq),
  .irq_en    (irq_en),
  .no_nest   (no_nest),
  .inserv    (inserv),
  .enter     (enter),
  .enter_lvl (enter_lvl),
  .ack       (ack),
  .ack_mask  (ack_mask),
  .active_id (active_id)
);

// File: tb/test_irq_collector.sv
module test_irq_collector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_lines = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_collector i_irq_collector (
    .clk       (clk),
    .rst       (rst),
    .irq_lines (irq_lines),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(cpu_irq), 32'd0);
    rd(12'h020, v); chk("R1 ctrl", v, 32'd0);
    rd(12'h160, v); chk("R1 tbase", v, 32'd0);
    rd(12'h060, v); chk("R1 src0", v, 32'd0);
    rd(12'h150, v); chk("R1 src15", v, 32'd0);
  endtask

  task automatic t_layout_alias();
    logic [31:0] v;
    wr(12'h070, 32'hFFFF_FFFF); rd(12'h070, v); chk("R2 byte mask", v, 32'h0F0F_0F0F);
    wr(12'h070, 32'h0);
    wr(12'h020, 32'h0001_0000); rd(12'h020, v); chk("R3 plain", v, 32'h0001_0000);
    wr(12'h024, 32'h0004_0000); rd(12'h020, v); chk("R3 set", v, 32'h0005_0000);
    wr(12'h028, 32'h0001_0000); rd(12'h020, v); chk("R3 clear", v, 32'h0004_0000);
    wr(12'h02C, 32'h000C_0000); rd(12'h020, v); chk("R3 toggle", v, 32'h0008_0000);
    wr(12'h020, 32'h0);
    wr(12'h160, 32'hFFFF_FFFF); rd(12'h160, v); chk("R3 tbase keep", v, 32'hFFFF_FFFC);
  endtask

  task automatic t_raw();
    logic [31:0] v;
    irq_lines = 64'hA5A5_0000_1234_5678;
    rd(12'h040, v); chk("R4 raw low", v, 32'h1234_5678);
    wr(12'h040, 32'h0);
    rd(12'h050, v); chk("R4 raw high", v, 32'hA5A5_0000);
    rd(12'h040, v); chk("R4 raw write ignored", v, 32'h1234_5678);
    irq_lines = '0;
  endtask

  task automatic t_present_mode0();
    logic [31:0] v;
    wr(12'h160, 32'h0000_1000);
    wr(12'h080, 32'h0000_0500);          // source 9: enable, level 1
    irq_lines[9] = 1'b1;
    settle(); settle();
    chk("R5 gated off", 32'(cpu_irq), 32'd0);
    wr(12'h024, 32'h0001_0000);
    chk("R5 one-cycle delay", 32'(cpu_irq), 32'd0);
    settle();
    chk("R5 raised", 32'(cpu_irq), 32'd1);
    rd(12'h000, v); chk("R7 vector", v, 32'h0000_1024);
    rd(12'h030, v); chk("R7 status", v, 32'd9);
    settle();
    chk("R8 read no entry", 32'(cpu_irq), 32'd1);
    wr(12'h000, 32'h0);
    settle();
    chk("R8 write entry", 32'(cpu_irq), 32'd0);
    rd(12'h000, v); chk("R7 vector held", v, 32'h0000_1024);
  endtask

  task automatic t_nesting();
    logic [31:0] v;
    wr(12'h0B0, 32'h0000_0005);          // source 20: enable, level 1
    irq_lines[20] = 1'b1;
    settle(); settle();
    chk("R10 equal level blocked", 32'(cpu_irq), 32'd0);
    wr(12'h100, 32'h0000_0007);          // source 40: enable, level 3
    irq_lines[40] = 1'b1;
    settle(); settle();
    chk("R10 higher level nests", 32'(cpu_irq), 32'd1);
    rd(12'h000, v); chk("R7 nested vector", v, 32'h0000_10A0);
    wr(12'h000, 32'h0);
    settle();
    chk("R10 level3 in service", 32'(cpu_irq), 32'd0);
    rd(12'h030, v); chk("R7 status held", v, 32'd40);
    wr(12'h010, 32'h0000_0008);
    settle();
    chk("R10 ack level3", 32'(cpu_irq), 32'd1);
    irq_lines[40] = 1'b0;
    settle(); settle();
    chk("R10 level1 still blocks", 32'(cpu_irq), 32'd0);
    wr(12'h010, 32'h0000_0002);
    settle();
    chk("R10 ack level1", 32'(cpu_irq), 32'd1);
    rd(12'h030, v); chk("R6 tie lowest", v, 32'd9);
    wr(12'h0BC, 32'h0000_0003);          // source 20 level 1 -> 2
    settle();
    rd(12'h030, v); chk("R6 higher level wins", v, 32'd20);
    wr(12'h020, 32'h0);
    wr(12'h080, 32'h0); wr(12'h0B0, 32'h0); wr(12'h100, 32'h0);
    irq_lines = '0;
    wr(12'h010, 32'h0000_000F);
  endtask

  task automatic t_read_entry();
    logic [31:0] v;
    wr(12'h020, 32'h0005_0000);          // enable + read entry
    wr(12'h060, 32'h0E00_0000);          // source 3: soft, enable, level 2
    settle(); settle();
    chk("R12 soft request", 32'(cpu_irq), 32'd1);
    rd(12'h040, v); chk("R4 raw excludes soft", v, 32'd0);
    rd(12'h000, v); chk("R9 read vector", v, 32'h0000_100C);
    settle();
    chk("R9 read entered", 32'(cpu_irq), 32'd0);
    wr(12'h024, 32'h0008_0000);          // nesting off
    wr(12'h070, 32'h0000_0F00);          // source 5: soft, enable, level 3
    settle(); settle();
    chk("R11 no nesting", 32'(cpu_irq), 32'd0);
    wr(12'h028, 32'h0008_0000);
    settle(); settle();
    chk("R11 nesting back", 32'(cpu_irq), 32'd1);
    rd(12'h000, v); chk("R9 nested read vector", v, 32'h0000_1014);
    settle();
    chk("R9 nested entered", 32'(cpu_irq), 32'd0);
    wr(12'h020, 32'h0); wr(12'h060, 32'h0); wr(12'h070, 32'h0);
    wr(12'h010, 32'h0000_000F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_layout_alias();
    t_raw();
    t_present_mode0();
    t_nesting();
    t_read_entry();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule